// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block is the memory-side control for one bank pair of a synchronous DRAM. It receives already-decoded commands (read, write, burst stop, mode set), a starting column, the clock-enable pin and the two byte masks. From these it produces, cycle by cycle, the internal column that the storage array must access, a per-byte write enable for write beats, a data-valid strobe and column tag for read data reaching the bus, and a per-byte output enable for the data pins. Row activation, refresh and the array itself live elsewhere.

A mode word sets the burst length to 4 or 8. Words that are not a supported combination are rejected and the old setting is kept. Bursts follow a serial order that wraps inside an aligned group of columns. Write data is taken on the command edge itself. Read data reaches the bus two clocks after the array access, without gaps between beats. A low clock enable suspends the whole block one edge later, and the block resumes exactly where it stopped.

The sequencer is a three-state machine. ST_IDLE moves to ST_READ on a read command and to ST_WRITE on a write command. ST_READ and ST_WRITE move back to ST_IDLE when the last beat is issued or on a stop. A new read or write in any state restarts the machine in ST_READ or ST_WRITE. While the clock enable is suspended, no transition happens.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the burst length is 4 (`mode_bl8`=0). A mode-set command (`cmd`=4) loads the setting when it is accepted: the clock is enabled, `banks_idle`=1, and `mode_word` is 10'h022 (length 4) or 10'h023 (length 8). A valid word has bits 9, 8, 7 and 3 at 0, bits 6..4 at 010, and bits 2..0 at 010 or 011. The new length shows on `mode_bl8` after that edge.
- R2: A mode-set with any other word, or with `banks_idle`=0, leaves `mode_bl8` unchanged.
- R3: A burst issues exactly BL beats on consecutive enabled cycles. Beat k has the upper column bits of the start column. Its low log2(BL) bits are (start + k) mod BL.
- R4: A write command (`cmd`=2) issues its first beat in the command cycle itself: `col_valid`=1 and `col_out`=`col_in`.
- R5: During a write beat, `wr_be[0]` = NOT `dqm[0]` (data bits 7..0) and `wr_be[1]` = NOT `dqm[1]` (bits 15..8), taken from the same cycle. Outside write beats, `wr_be` is 0.
- R6: A read command (`cmd`=1) issues array beats the same way. Each beat appears on `rd_valid`/`rd_col` two enabled edges later, so consecutive beats leave no gaps.
- R7: `dq_oe[b]` is 1 only while `rd_valid`=1 and `dqm[b]` was 0 two enabled edges earlier. Otherwise the pins are released.
- R8: The clock enable is sampled each edge. A low sample freezes the block at the following edge: beats, sequence position and read outputs all hold. Operation continues once a high sample has been taken.
- R9: A stop command (`cmd`=3) issues no beat and ends the burst. Read beats already issued still reach the bus.
- R10: A read or write command during a burst abandons it and starts a new sequence from the new column. Read beats already in flight still emerge.
- R11: Any command presented in a suspended cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, sampled each edge |
| cmd | input | 3 | 0 none, 1 read, 2 write, 3 stop, 4 mode set |
| col_in | input | COL_W | Starting column of a read or write |
| mode_word | input | 10 | Mode word for a mode set |
| banks_idle | input | 1 | Both banks deactivated |
| dqm | input | 2 | Byte masks, bit 0 lower byte, bit 1 upper byte |
| col_out | output | COL_W | Column accessed this cycle |
| col_valid | output | 1 | An array beat is issued this cycle |
| wr_be | output | 2 | Per-byte write enable for this beat |
| rd_valid | output | 1 | Read data on the bus this cycle |
| rd_col | output | COL_W | Column whose data is on the bus |
| dq_oe | output | 2 | Per-byte output enable of the data pins |
| mode_bl8 | output | 1 | Current burst length is 8 |

## Verification
The bench walks every start column at both burst lengths. Here an adder that carries into the upper bits, instead of wrapping inside the group, would leave the aligned group. It places masks on each beat of writes and reads. A design that pipelined the write mask, or did not delay the read mask, would enable the wrong byte on the wrong cycle. Suspend windows are placed mid-read and mid-write, and commands are given during suspension. An off-by-one in clock-enable handling would then skip or repeat a column, or accept a stray command. Rejected mode words, each breaking a different field, would flip `mode_bl8` in a design that checked only the length bits.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_STOP  = 3'd3,
        CMD_MODE  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    localparam int MODE_W   = 10;
    localparam int MASK_W   = 2;
    localparam int MAX_BL   = 8;

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              set_req,
    input  logic              banks_idle,
    input  logic [MODE_W-1:0] word,
    output logic              bl8
);

    logic word_ok;
    logic take;

    // bits 9..3 = 0000100 (CL 2, serial, reserved zero), bits 2..0 = 01x
    always_comb begin
        word_ok = (word[9:3] == 7'b0000100) && (word[2:1] == 2'b01);
        take    = en && set_req && banks_idle && word_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bl8 <= 1'b0;
        else if (take)
            bl8 <= word[0];
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(bl8)); // R2
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (bl8 == $past(word[0]))); // R1

endmodule

// File: rtl/sdr_col_seq.sv
module sdr_col_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       cmd,
    input  logic [COL_W-1:0] col_in,
    input  logic             bl8,
    output logic             beat_v,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_col
);

    localparam int CNT_W = $clog2(MAX_BL) + 1;

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [CNT_W-1:0] bl_m1;
    logic             is_rd, is_wr, is_start, is_stop;

    function automatic logic [COL_W-1:0] wrap_next(input logic [COL_W-1:0] c,
                                                   input logic b8);
        logic [COL_W-1:0] low;
        low = b8 ? COL_W'(7) : COL_W'(3);
        return (c & ~low) | ((c + COL_W'(1)) & low);
    endfunction

    always_comb begin
        is_rd    = (cmd == CMD_READ);
        is_wr    = (cmd == CMD_WRITE);
        is_start = is_rd || is_wr;
        is_stop  = (cmd == CMD_STOP);
        bl_m1    = bl8 ? CNT_W'(7) : CNT_W'(3);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            left_q  <= left_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        left_d  = left_q;
        if (en) begin
            if (is_start) begin
                state_d = is_wr ? ST_WRITE : ST_READ;
                col_d   = wrap_next(col_in, bl8);
                left_d  = bl_m1;
            end else if (is_stop) begin
                state_d = ST_IDLE;
            end else if (state_q != ST_IDLE) begin
                col_d  = wrap_next(col_q, bl8);
                left_d = left_q - CNT_W'(1);
                if (left_q == CNT_W'(1))
                    state_d = ST_IDLE;
            end
        end
    end

    // beat outputs
    always_comb begin
        beat_v   = 1'b0;
        beat_wr  = 1'b0;
        beat_col = col_q;
        if (en) begin
            if (is_start) begin
                beat_v   = 1'b1;
                beat_wr  = is_wr;
                beat_col = col_in;
            end else if (!is_stop) begin
                unique case (state_q)
                    ST_IDLE:  ;
                    ST_READ:  beat_v = 1'b1;
                    ST_WRITE: begin
                        beat_v  = 1'b1;
                        beat_wr = 1'b1;
                    end
                    default:  ;
                endcase
            end
        end
    end

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state_q) && $stable(col_q) && $stable(left_q))); // R8
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_STOP) |=> (state_q == ST_IDLE)); // R9
    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (left_q != '0 && left_q < CNT_W'(MAX_BL))); // R3
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_start) |=> (state_q != ST_IDLE)); // R10

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_v,
    input  logic [COL_W-1:0]  in_col,
    input  logic [MASK_W-1:0] in_mask,
    output logic              out_v,
    output logic [COL_W-1:0]  out_col,
    output logic [MASK_W-1:0] out_mask
);

    logic              v_q [RD_LAT];
    logic [COL_W-1:0]  c_q [RD_LAT];
    logic [MASK_W-1:0] m_q [RD_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_LAT; i++) begin
                v_q[i] <= 1'b0;
                c_q[i] <= '0;
                m_q[i] <= '0;
            end
        end else if (en) begin
            v_q[0] <= in_v;
            c_q[0] <= in_col;
            m_q[0] <= in_mask;
            for (int i = 1; i < RD_LAT; i++) begin
                v_q[i] <= v_q[i-1];
                c_q[i] <= c_q[i-1];
                m_q[i] <= m_q[i-1];
            end
        end
    end

    assign out_v    = v_q[RD_LAT-1];
    assign out_col  = c_q[RD_LAT-1];
    assign out_mask = m_q[RD_LAT-1];

    AST_PIPE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_v) && $stable(out_col) && $stable(out_mask))); // R8

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [2:0]       cmd,
    input  logic [COL_W-1:0] col_in,
    input  logic [9:0]       mode_word,
    input  logic             banks_idle,
    input  logic [1:0]       dqm,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic [1:0]       wr_be,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col,
    output logic [1:0]       dq_oe,
    output logic             mode_bl8
);

    logic              cke_q;
    logic              beat_v, beat_wr;
    logic [COL_W-1:0]  beat_col;
    logic [MASK_W-1:0] rd_mask;

    // one-edge clock-enable latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_q <= 1'b1;
        else
            cke_q <= cke;
    end

    sdr_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cke_q),
        .set_req    (cmd == CMD_MODE),
        .banks_idle (banks_idle),
        .word       (mode_word),
        .bl8        (mode_bl8)
    );

    sdr_col_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cke_q),
        .cmd      (cmd),
        .col_in   (col_in),
        .bl8      (mode_bl8),
        .beat_v   (beat_v),
        .beat_wr  (beat_wr),
        .beat_col (beat_col)
    );

    sdr_rd_pipe #(.COL_W(COL_W), .RD_LAT(RD_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cke_q),
        .in_v     (beat_v & ~beat_wr),
        .in_col   (beat_col),
        .in_mask  (dqm),
        .out_v    (rd_valid),
        .out_col  (rd_col),
        .out_mask (rd_mask)
    );

    assign col_out   = beat_col;
    assign col_valid = beat_v;
    assign wr_be     = {MASK_W{beat_v & beat_wr}} & ~dqm;
    assign dq_oe     = {MASK_W{rd_valid}} & ~rd_mask;

    AST_OE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> rd_valid); // R7
    AST_WBE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be != '0) |-> (col_valid && cke_q)); // R5

endmodule

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cke;
    logic [2:0]       cmd;
    logic [COL_W-1:0] col_in;
    logic [9:0]       mode_word;
    logic             banks_idle;
    logic [1:0]       dqm;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic [1:0]       wr_be;
    logic             rd_valid;
    logic [COL_W-1:0] rd_col;
    logic [1:0]       dq_oe;
    logic             mode_bl8;

    always #5 clk = ~clk;

    sdram_burst_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .col_in(col_in),
        .mode_word(mode_word), .banks_idle(banks_idle), .dqm(dqm),
        .col_out(col_out), .col_valid(col_valid), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_col(rd_col), .dq_oe(dq_oe), .mode_bl8(mode_bl8)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural reference state
    bit m_en    = 1'b1;
    bit m_bl8   = 1'b0;
    bit m_act   = 1'b0;
    bit m_wr    = 1'b0;
    int m_start = 0;
    int m_k     = 0;
    int pq_v[$];
    int pq_col[$];
    int pq_m[$];

    function automatic int seq_col(int s, int k, bit b8);
        int n = b8 ? 8 : 4;
        return s - (s % n) + ((s % n) + k) % n;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] c, input int col, input logic [1:0] m,
                       input logic k, input logic [9:0] w, input logic idle,
                       input string tag);
        int e_bv, e_bw, e_bc, e_oe;
        bit st, stp;
        logic [1:0] nm;
        @(negedge clk);
        cmd = c; col_in = COL_W'(col); dqm = m; cke = k;
        mode_word = w; banks_idle = idle;
        #1;
        nm  = ~m;
        st  = m_en && (c == 3'd1 || c == 3'd2);
        stp = m_en && (c == 3'd3);
        e_bv = 0; e_bw = 0; e_bc = 0;
        if (st) begin
            e_bv = 1; e_bw = (c == 3'd2); e_bc = col;
        end else if (!stp && m_en && m_act) begin
            e_bv = 1; e_bw = m_wr; e_bc = seq_col(m_start, m_k, m_bl8);
        end
        check(tag, "col_valid", int'(col_valid), e_bv);
        if (e_bv != 0) check(tag, "col_out", int'(col_out), e_bc);
        check(tag, "wr_be", int'(wr_be), (e_bw != 0) ? int'(nm) : 0);
        check(tag, "rd_valid", int'(rd_valid), pq_v[0]);
        if (pq_v[0] != 0) check(tag, "rd_col", int'(rd_col), pq_col[0]);
        e_oe = (pq_v[0] != 0) ? ((~pq_m[0]) & 3) : 0;
        check(tag, "dq_oe", int'(dq_oe), e_oe);
        check(tag, "mode_bl8", int'(mode_bl8), int'(m_bl8));
        @(posedge clk);
        if (m_en) begin
            pq_v.push_back((e_bv != 0 && e_bw == 0) ? 1 : 0);
            pq_col.push_back(e_bc);
            pq_m.push_back(int'(m));
            void'(pq_v.pop_front());
            void'(pq_col.pop_front());
            void'(pq_m.pop_front());
            if (st) begin
                m_act = 1'b1; m_wr = (c == 3'd2); m_start = col; m_k = 1;
            end else if (stp) begin
                m_act = 1'b0;
            end else if (m_act) begin
                m_k++;
                if (m_k == (m_bl8 ? 8 : 4)) m_act = 1'b0;
            end
            if (c == 3'd4 && idle && (w == 10'h022 || w == 10'h023))
                m_bl8 = w[0];
        end
        m_en = k;
    endtask

    task automatic idle_n(int n, string tag);
        for (int i = 0; i < n; i++) cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, tag);
    endtask

    task automatic set_mode(logic [9:0] w, logic idle, string tag);
        cyc(3'd4, 0, 2'b00, 1'b1, w, idle, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hung expected done");
        summary();
        $finish;
    end

    initial begin
        pq_v   = '{0, 0};
        pq_col = '{0, 0};
        pq_m   = '{0, 0};
        rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; col_in = '0;
        mode_word = '0; banks_idle = 1'b1; dqm = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state, default burst length 4
        idle_n(2, "R1");

        // R3 R4 R6: every start at length 4
        for (int s = 0; s < 4; s++) begin
            cyc(3'd2, 'h40 + s, 2'b00, 1'b1, 10'h0, 1'b1, "R4");
            idle_n(3, "R3");
            cyc(3'd1, 'h80 + s, 2'b00, 1'b1, 10'h0, 1'b1, "R6");
            idle_n(5, "R3");
        end
        cyc(3'd1, 'hFE, 2'b00, 1'b1, 10'h0, 1'b1, "R3");
        idle_n(5, "R3");

        // R1: switch to length 8
        set_mode(10'h023, 1'b1, "R1");
        idle_n(1, "R1");
        for (int s = 0; s < 8; s++) begin
            cyc(3'd2, 'h28 + s, 2'b00, 1'b1, 10'h0, 1'b1, "R4");
            idle_n(7, "R3");
            cyc(3'd1, 'hB8 + s, 2'b00, 1'b1, 10'h0, 1'b1, "R6");
            idle_n(9, "R3");
        end
        // gapless back-to-back reads
        cyc(3'd1, 'h13, 2'b00, 1'b1, 10'h0, 1'b1, "R6");
        idle_n(7, "R6");
        cyc(3'd1, 'h6D, 2'b00, 1'b1, 10'h0, 1'b1, "R6");
        idle_n(10, "R6");

        // R2: rejected words and busy banks leave length 8
        set_mode(10'h0A2, 1'b1, "R2");
        set_mode(10'h122, 1'b1, "R2");
        set_mode(10'h032, 1'b1, "R2");
        set_mode(10'h012, 1'b1, "R2");
        set_mode(10'h02A, 1'b1, "R2");
        set_mode(10'h222, 1'b1, "R2");
        set_mode(10'h020, 1'b1, "R2");
        set_mode(10'h026, 1'b1, "R2");
        set_mode(10'h022, 1'b0, "R2");
        idle_n(1, "R2");
        // R11: mode set during suspension ignored
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R11");
        cyc(3'd4, 0, 2'b00, 1'b1, 10'h022, 1'b1, "R11");
        idle_n(2, "R11");
        // back to length 4
        set_mode(10'h022, 1'b1, "R1");
        idle_n(1, "R1");

        // R5: write masks on each beat
        cyc(3'd2, 'h60, 2'b01, 1'b1, 10'h0, 1'b1, "R5");
        cyc(3'd0, 0, 2'b10, 1'b1, 10'h0, 1'b1, "R5");
        cyc(3'd0, 0, 2'b11, 1'b1, 10'h0, 1'b1, "R5");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R5");
        cyc(3'd0, 0, 2'b11, 1'b1, 10'h0, 1'b1, "R5");

        // R7: read masks two cycles ahead of the data
        cyc(3'd1, 'h71, 2'b00, 1'b1, 10'h0, 1'b1, "R7");
        cyc(3'd0, 0, 2'b01, 1'b1, 10'h0, 1'b1, "R7");
        cyc(3'd0, 0, 2'b10, 1'b1, 10'h0, 1'b1, "R7");
        cyc(3'd0, 0, 2'b11, 1'b1, 10'h0, 1'b1, "R7");
        cyc(3'd0, 0, 2'b01, 1'b1, 10'h0, 1'b1, "R7");
        cyc(3'd0, 0, 2'b10, 1'b1, 10'h0, 1'b1, "R7");
        idle_n(3, "R7");

        // R8: suspend mid read and mid write
        cyc(3'd1, 'h31, 2'b00, 1'b1, 10'h0, 1'b1, "R8");
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R8");
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R8");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R8");
        idle_n(6, "R8");
        cyc(3'd2, 'h36, 2'b00, 1'b1, 10'h0, 1'b1, "R8");
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R8");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R8");
        idle_n(5, "R8");

        // R11: read and stop during suspension ignored
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R11");
        cyc(3'd1, 'h55, 2'b00, 1'b1, 10'h0, 1'b1, "R11");
        idle_n(3, "R11");
        cyc(3'd1, 'h4A, 2'b00, 1'b1, 10'h0, 1'b1, "R11");
        cyc(3'd0, 0, 2'b00, 1'b0, 10'h0, 1'b1, "R11");
        cyc(3'd3, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R11");
        idle_n(6, "R11");

        // R9: stop mid read and mid write
        cyc(3'd1, 'h22, 2'b00, 1'b1, 10'h0, 1'b1, "R9");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R9");
        cyc(3'd3, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R9");
        idle_n(4, "R9");
        cyc(3'd2, 'h25, 2'b00, 1'b1, 10'h0, 1'b1, "R9");
        cyc(3'd3, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R9");
        idle_n(3, "R9");

        // R10: restart mid burst
        cyc(3'd1, 'h12, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        cyc(3'd1, 'h19, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        idle_n(6, "R10");
        cyc(3'd2, 'h17, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        cyc(3'd0, 0, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        cyc(3'd1, 'h1E, 2'b00, 1'b1, 10'h0, 1'b1, "R10");
        idle_n(6, "R10");

        summary();
        $finish;
    end

endmodule